// File: doc/BRIEF.md
# FIFO Service Flags with Receive DMA Steering

This block sits beside the word-wide transmit and receive FIFOs of a serial link controller and turns their occupancy counts into service flags. The transmit flag says that software or a bus master may push data; the receive flag says that data may be pulled out. Each flag can demand either a single word or a burst of four words, so that a master which moves four words per request never has to poll status in between.

The receive service request goes to one of two places. If receive DMA is disabled, it goes to an interrupt line. If receive DMA is enabled, the interrupt is held off and the request goes to the DMA engine. The DMA enable switches itself off when a sampled descriptor has no successor pointer, or when that descriptor is not owned by the DMA. The block also reports which bytes of the last word of a frame are valid. It does so only while that tail word lies within the words that the receive flag does not already cover.

Top module: `fifo_svc_flags`

## Requirements
- R1: With `tx_burst4`=0, `tx_avail` is 1 exactly when at least one transmit word is free, i.e. the sampled `tx_level` is 7 or less (depth 8).
- R2: With `tx_burst4`=1, `tx_avail` is 1 exactly when at least four transmit words are free, i.e. `tx_level` is 4 or less.
- R3: With `rx_burst4`=0, `rx_avail` is 1 exactly when `rx_level` is 1 or more.
- R4: With `rx_burst4`=1, `rx_avail` is 1 exactly when `rx_level` is 4 or more.
- R5: A level input above 8 is treated as 8 (FIFO full).
- R6: `rx_tail_mask` bit i is set when byte i of the frame's last word is valid. A `rx_tail_bytes` code of 1, 2 or 3 means that many low bytes are valid (0001, 0011, 0111), and code 0 means a full word (1111).
- R7: `rx_tail_mask` is nonzero only while `rx_frame_end` is 1 and the receive level is between 1 and the window bound. The bound is 1 when `rx_burst4`=0 and 3 when `rx_burst4`=1. Otherwise the mask reads 0.
- R8: When `rx_avail` is 1, `rx_irq` is 1 if `dma_rx_en` is 0, and `rx_dma_req` is 1 if `dma_rx_en` is 1. Neither is ever 1 without `rx_avail`.
- R9: A `dma_set` pulse makes `dma_rx_en` 1 on the next clock, and a `dma_clr` pulse makes it 0. Clear wins over set.
- R10: `desc_sample` with `desc_null`=1 makes `dma_rx_en` 0 on the next clock.
- R11: `desc_sample` with `desc_dma_owned`=0 makes `dma_rx_en` 0 on the next clock.
- R12: A descriptor self-clear wins over a `dma_set` pulse in the same cycle.
- R13: All outputs are registered and reset to 0, and each reflects the inputs sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_burst4 | input | 1 | Transmit flag needs four free words |
| rx_burst4 | input | 1 | Receive flag needs four held words |
| tx_level | input | 4 | Transmit FIFO occupancy in words |
| rx_level | input | 4 | Receive FIFO occupancy in words |
| rx_frame_end | input | 1 | Last word in receive FIFO ends a frame |
| rx_tail_bytes | input | 2 | Valid bytes in that last word (0 means 4) |
| dma_set | input | 1 | Pulse: enable receive DMA |
| dma_clr | input | 1 | Pulse: disable receive DMA |
| desc_sample | input | 1 | Descriptor fields below are valid this cycle |
| desc_null | input | 1 | Next descriptor pointer is null |
| desc_dma_owned | input | 1 | Descriptor owner is the DMA |
| tx_avail | output | 1 | Transmit FIFO can accept the configured burst |
| rx_avail | output | 1 | Receive FIFO holds the configured burst |
| rx_irq | output | 1 | Receive service interrupt request |
| rx_dma_req | output | 1 | Receive DMA transfer request |
| dma_rx_en | output | 1 | Receive DMA enable state |
| rx_tail_mask | output | 4 | Valid-byte mask of the frame's last word |

## Verification
On every cycle, the assertions check how the flags follow the threshold for whichever burst mode is selected. They also check that the tail mask goes quiet outside its window, that interrupt and DMA requests both depend on the flag and exclude each other, and that both descriptor conditions kill the enable on the next clock. What only the scenarios can show are the exact mask encodings for each byte count, the saturation of over-range levels, the priorities among simultaneous set, clear and descriptor events, and the one-clock latency seen at the ports after reset.

// File: rtl/fifo_svc_pkg.sv
package fifo_svc_pkg;

    localparam int MASK_W = 4;

    typedef struct packed {
        logic              tx_avail;
        logic              rx_avail;
        logic              rx_irq;
        logic              rx_dma_req;
        logic              dma_en;
        logic [MASK_W-1:0] tail_mask;
    } svc_state_t;

endpackage

// File: rtl/fifo_level_thresh.sv
module fifo_level_thresh #(
    parameter int DEPTH     = 8,
    parameter int CNT_W     = 4,
    parameter int BURST     = 4,
    parameter bit FREE_SIDE = 1'b0
) (
    input  logic [CNT_W-1:0] level,
    input  logic             burst_mode,
    output logic             hit
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] BURST_C = CNT_W'(BURST);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    logic [CNT_W-1:0] sat_level;
    logic [CNT_W-1:0] metric;
    logic [CNT_W-1:0] need;

    always_comb begin
        sat_level = (level > DEPTH_C) ? DEPTH_C : level;
        need      = burst_mode ? BURST_C : ONE_C;
    end

    generate
        if (FREE_SIDE) begin : g_free
            always_comb metric = DEPTH_C - sat_level;
        end else begin : g_fill
            always_comb metric = sat_level;
        end
    endgenerate

    always_comb hit = (metric >= need);

endmodule

// File: rtl/fifo_tail_mask.sv
module fifo_tail_mask #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4,
    parameter int BURST = 4,
    parameter int BYTES = 4
) (
    input  logic                       frame_end,
    input  logic [$clog2(BYTES)-1:0]   tail_bytes,
    input  logic [CNT_W-1:0]           level,
    input  logic                       burst_mode,
    output logic [BYTES-1:0]           mask
);
    localparam int               SEL_W   = $clog2(BYTES);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] WIN4_C  = CNT_W'(BURST - 1);
    localparam logic [CNT_W-1:0] WIN1_C  = CNT_W'(1);

    logic [CNT_W-1:0] sat_level;
    logic [CNT_W-1:0] bound;
    logic             in_window;
    logic [BYTES-1:0] raw;

    always_comb begin
        sat_level = (level > DEPTH_C) ? DEPTH_C : level;
        bound     = burst_mode ? WIN4_C : WIN1_C;
        in_window = frame_end && (sat_level != '0) && (sat_level <= bound);
    end

    generate
        for (genvar b = 0; b < BYTES; b++) begin : g_byte
            always_comb raw[b] = (tail_bytes == '0) || (SEL_W'(b) < tail_bytes);
        end
    endgenerate

    always_comb mask = in_window ? raw : '0;

endmodule

// File: rtl/fifo_dma_gate.sv
module fifo_dma_gate (
    input  logic en_q,
    input  logic set_req,
    input  logic clr_req,
    input  logic desc_sample,
    input  logic desc_null,
    input  logic desc_dma_owned,
    output logic en_d
);
    logic desc_kill;

    always_comb begin
        desc_kill = desc_sample && (desc_null || !desc_dma_owned);
        if (desc_kill || clr_req) begin
            en_d = 1'b0;
        end else if (set_req) begin
            en_d = 1'b1;
        end else begin
            en_d = en_q;
        end
    end

endmodule

// File: rtl/fifo_svc_flags.sv
module fifo_svc_flags
    import fifo_svc_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4,
    parameter int BURST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_burst4,
    input  logic              rx_burst4,
    input  logic [CNT_W-1:0]  tx_level,
    input  logic [CNT_W-1:0]  rx_level,
    input  logic              rx_frame_end,
    input  logic [1:0]        rx_tail_bytes,
    input  logic              dma_set,
    input  logic              dma_clr,
    input  logic              desc_sample,
    input  logic              desc_null,
    input  logic              desc_dma_owned,
    output logic              tx_avail,
    output logic              rx_avail,
    output logic              rx_irq,
    output logic              rx_dma_req,
    output logic              dma_rx_en,
    output logic [MASK_W-1:0] rx_tail_mask
);
    svc_state_t        st_d, st_q;
    logic              tx_hit_d;
    logic              rx_hit_d;
    logic              en_d;
    logic [MASK_W-1:0] mask_d;

    fifo_level_thresh #(.DEPTH(DEPTH), .CNT_W(CNT_W), .BURST(BURST), .FREE_SIDE(1'b1)) u_tx_thresh (
        .level(tx_level), .burst_mode(tx_burst4), .hit(tx_hit_d)
    );

    fifo_level_thresh #(.DEPTH(DEPTH), .CNT_W(CNT_W), .BURST(BURST), .FREE_SIDE(1'b0)) u_rx_thresh (
        .level(rx_level), .burst_mode(rx_burst4), .hit(rx_hit_d)
    );

    fifo_tail_mask #(.DEPTH(DEPTH), .CNT_W(CNT_W), .BURST(BURST), .BYTES(MASK_W)) u_tail (
        .frame_end(rx_frame_end), .tail_bytes(rx_tail_bytes), .level(rx_level),
        .burst_mode(rx_burst4), .mask(mask_d)
    );

    fifo_dma_gate u_dma (
        .en_q(st_q.dma_en), .set_req(dma_set), .clr_req(dma_clr),
        .desc_sample(desc_sample), .desc_null(desc_null),
        .desc_dma_owned(desc_dma_owned), .en_d(en_d)
    );

    always_comb begin
        st_d            = st_q;
        st_d.tx_avail   = tx_hit_d;
        st_d.rx_avail   = rx_hit_d;
        st_d.dma_en     = en_d;
        st_d.rx_irq     = rx_hit_d && !en_d;
        st_d.rx_dma_req = rx_hit_d && en_d;
        st_d.tail_mask  = mask_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_avail     = st_q.tx_avail;
    assign rx_avail     = st_q.rx_avail;
    assign rx_irq       = st_q.rx_irq;
    assign rx_dma_req   = st_q.rx_dma_req;
    assign dma_rx_en    = st_q.dma_en;
    assign rx_tail_mask = st_q.tail_mask;

endmodule

// File: rtl/fifo_svc_flags_chk.sv
module fifo_svc_flags_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_burst4,
    input logic             rx_burst4,
    input logic [CNT_W-1:0] tx_level,
    input logic [CNT_W-1:0] rx_level,
    input logic             rx_frame_end,
    input logic             desc_sample,
    input logic             desc_null,
    input logic             desc_dma_owned,
    input logic             tx_avail,
    input logic             rx_avail,
    input logic             rx_irq,
    input logic             rx_dma_req,
    input logic             dma_rx_en,
    input logic [3:0]       rx_tail_mask
);
    assert_tx_one_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_burst4 && tx_level < 4'd8) |=> tx_avail);

    assert_tx_four_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_burst4 && tx_level > 4'd4) |=> !tx_avail);

    assert_rx_one_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_burst4 && rx_level == 4'd0) |=> !rx_avail);

    assert_rx_four_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_burst4 && rx_level < 4'd4) |=> !rx_avail);

    assert_tail_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_frame_end || rx_level == 4'd0) |=> (rx_tail_mask == 4'd0));

    assert_req_steer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rx_irq, rx_dma_req}) <= 1 && ((rx_irq || rx_dma_req) -> rx_avail));

    assert_null_kill_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_sample && desc_null) |=> !dma_rx_en);

    assert_owner_kill_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_sample && !desc_dma_owned) |=> !dma_rx_en);

endmodule

bind fifo_svc_flags fifo_svc_flags_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_burst4(tx_burst4), .rx_burst4(rx_burst4),
    .tx_level(tx_level), .rx_level(rx_level), .rx_frame_end(rx_frame_end),
    .desc_sample(desc_sample), .desc_null(desc_null), .desc_dma_owned(desc_dma_owned),
    .tx_avail(tx_avail), .rx_avail(rx_avail), .rx_irq(rx_irq), .rx_dma_req(rx_dma_req),
    .dma_rx_en(dma_rx_en), .rx_tail_mask(rx_tail_mask)
);

// File: tb/fifo_svc_flags_tb_top.sv
module fifo_svc_flags_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_burst4 = 1'b0, rx_burst4 = 1'b0;
    logic [3:0] tx_level = 4'd0, rx_level = 4'd0;
    logic       rx_frame_end = 1'b0;
    logic [1:0] rx_tail_bytes = 2'd0;
    logic       dma_set = 1'b0, dma_clr = 1'b0;
    logic       desc_sample = 1'b0, desc_null = 1'b0, desc_dma_owned = 1'b1;
    logic       tx_avail, rx_avail, rx_irq, rx_dma_req, dma_rx_en;
    logic [3:0] rx_tail_mask;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    fifo_svc_flags dut_i (
        .clk(clk), .rst_n(rst_n), .tx_burst4(tx_burst4), .rx_burst4(rx_burst4),
        .tx_level(tx_level), .rx_level(rx_level), .rx_frame_end(rx_frame_end),
        .rx_tail_bytes(rx_tail_bytes), .dma_set(dma_set), .dma_clr(dma_clr),
        .desc_sample(desc_sample), .desc_null(desc_null), .desc_dma_owned(desc_dma_owned),
        .tx_avail(tx_avail), .rx_avail(rx_avail), .rx_irq(rx_irq), .rx_dma_req(rx_dma_req),
        .dma_rx_en(dma_rx_en), .rx_tail_mask(rx_tail_mask)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sat(input int lvl);
        return (lvl > 8) ? 8 : lvl;
    endfunction

    function automatic int exp_tx(input int lvl, input bit b4);
        return ((8 - sat(lvl)) >= (b4 ? 4 : 1)) ? 1 : 0;
    endfunction

    function automatic int exp_rx(input int lvl, input bit b4);
        return (sat(lvl) >= (b4 ? 4 : 1)) ? 1 : 0;
    endfunction

    function automatic int exp_mask(input bit fe, input int nb, input int lvl, input bit b4);
        if (!fe || sat(lvl) == 0 || sat(lvl) > (b4 ? 3 : 1)) return 0;
        case (nb)
            1: return 1;
            2: return 3;
            3: return 7;
            default: return 15;
        endcase
    endfunction

    // one clock: inputs were driven at a negedge, sample at the next negedge
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(); tick();
        // R13 reset values
        chk("R13 tx_avail reset", int'(tx_avail), 0);
        chk("R13 dma_rx_en reset", int'(dma_rx_en), 0);
        chk("R13 mask reset", int'(rx_tail_mask), 0);
        rst_n = 1'b1;
        tx_level = 4'd3;
        tick();
        chk("R13 tx_avail one clock after reset", int'(tx_avail), 1);
    endtask

    task automatic t_tx_levels();
        for (int m = 0; m < 2; m++) begin
            for (int l = 0; l < 16; l++) begin
                tx_burst4 = m[0];
                tx_level  = 4'(l);
                tick();
                if (l > 8) chk("R5 tx saturation", int'(tx_avail), exp_tx(l, m[0]));
                else if (m == 0) chk("R1 tx one-word", int'(tx_avail), exp_tx(l, 1'b0));
                else chk("R2 tx four-word", int'(tx_avail), exp_tx(l, 1'b1));
            end
        end
    endtask

    task automatic t_rx_levels();
        for (int m = 0; m < 2; m++) begin
            for (int l = 0; l < 16; l++) begin
                rx_burst4 = m[0];
                rx_level  = 4'(l);
                tick();
                if (l > 8) chk("R5 rx saturation", int'(rx_avail), exp_rx(l, m[0]));
                else if (m == 0) chk("R3 rx one-word", int'(rx_avail), exp_rx(l, 1'b0));
                else chk("R4 rx four-word", int'(rx_avail), exp_rx(l, 1'b1));
                // R8 interrupt path while DMA is off
                chk("R8 irq follows flag", int'(rx_irq), exp_rx(l, m[0]));
            end
        end
    endtask

    task automatic t_tail();
        for (int m = 0; m < 2; m++) begin
            for (int nb = 0; nb < 4; nb++) begin
                for (int l = 0; l < 6; l++) begin
                    for (int fe = 0; fe < 2; fe++) begin
                        rx_burst4     = m[0];
                        rx_tail_bytes = 2'(nb);
                        rx_level      = 4'(l);
                        rx_frame_end  = fe[0];
                        tick();
                        if (fe == 1 && l == 1) chk("R6 tail mask encoding", int'(rx_tail_mask), exp_mask(1'b1, nb, l, m[0]));
                        else chk("R7 tail mask window", int'(rx_tail_mask), exp_mask(fe[0], nb, l, m[0]));
                    end
                end
            end
        end
        rx_frame_end = 1'b0;
    endtask

    task automatic t_dma();
        rx_burst4 = 1'b0;
        rx_level  = 4'd2;
        dma_set   = 1'b1;
        tick();
        dma_set = 1'b0;
        chk("R9 set enables", int'(dma_rx_en), 1);
        chk("R8 dma request", int'(rx_dma_req), 1);
        chk("R8 irq masked", int'(rx_irq), 0);
        tick();
        chk("R9 enable holds", int'(dma_rx_en), 1);
        desc_sample = 1'b1; desc_null = 1'b1; desc_dma_owned = 1'b1;
        tick();
        desc_sample = 1'b0; desc_null = 1'b0;
        chk("R10 null pointer clears", int'(dma_rx_en), 0);
        chk("R8 irq after self-clear", int'(rx_irq), 1);
        dma_set = 1'b1;
        tick();
        dma_set = 1'b0;
        desc_sample = 1'b1; desc_dma_owned = 1'b0;
        tick();
        desc_sample = 1'b0; desc_dma_owned = 1'b1;
        chk("R11 foreign owner clears", int'(dma_rx_en), 0);
        dma_set = 1'b1; desc_sample = 1'b1; desc_null = 1'b1;
        tick();
        desc_sample = 1'b0; desc_null = 1'b0;
        chk("R12 kill beats set", int'(dma_rx_en), 0);
        tick();
        chk("R9 set after kill", int'(dma_rx_en), 1);
        dma_clr = 1'b1;
        tick();
        chk("R9 clear wins over set", int'(dma_rx_en), 0);
        dma_set = 1'b0;
        tick();
        dma_clr = 1'b0;
        desc_sample = 1'b1;
        tick();
        desc_sample = 1'b0;
        chk("R11 valid descriptor keeps state", int'(dma_rx_en), 0);
        rx_level = 4'd0;
        tick();
        chk("R8 no request without flag", int'(rx_irq) + int'(rx_dma_req), 0);
    endtask

    initial begin
        fork
            begin : watchdog
                repeat (50000) @(posedge clk);
                if (!done) begin
                    n_checks++;
                    n_fails++;
                    $display("FAIL watchdog: actual timeout expected completion");
                    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
                    $finish;
                end
            end
        join_none
        @(negedge clk);
        t_reset();
        t_tx_levels();
        t_rx_levels();
        t_tail();
        t_dma();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule